// File: doc/BRIEF.md
# SPI Command Frame Receiver with CRC

This block is the serial slave of a control port driven by a host over SCLK, SDI and a latch strobe. Bits are shifted in all the time, whatever the latch level. A command is decoded only when the latch rises, using whatever the shift register holds at that moment. The command field is an 8-bit address followed by a 16-bit data word. The decoded result is one of four things: a one-cycle write strobe toward the register file, a read-back load, a watchdog feed, or an update of the block's own configuration.

An optional frame check adds an 8-bit CRC (polynomial x^8+x^2+x+1) after the 24 command bits, which gives a 32-bit frame. A frame whose remainder is not zero takes no action and sets a sticky fault flag. An optional communication watchdog expects feed frames within a selectable timeout, counted in system clock ticks. If no feed arrives in time, it raises its own sticky flag. The open-drain style `alarm_n` output is low while either flag is set. Read-back data are shifted out MSB first on SDO during the next frame.

Top module: `spi_cmd_rx`

## Requirements
- R1: Frames are sampled MSB first on rising SCLK, with the address in bits [23:16] and data in [15:0] of the 24-bit command. Bits shift in at any latch level, and only a rising latch edge decodes the shifted command.
- R2: Addresses 0x01, 0x55, 0x56, 0x57, 0x58 and 0x59 produce a single-cycle `wr_valid` pulse carrying that address and data. The pulse is high after the third rising `clk` edge that follows the latch going high.
- R3: Addresses 0x00 (no-op), 0x02 (read), 0x95 (feed) and every unlisted address produce no write strobe.
- R4: A write to 0x57 sets the block's own configuration: data bit 2 enables CRC framing, bit 3 enables the watchdog, and bits [1:0] select the timeout as 00=10 ms, 01=51 ms, 10=102 ms, 11=204 ms.
- R5: With CRC enabled, the frame is 32 bits. The command is the first 24 bits, and the CRC-8 remainder over all 32 bits (initial value 0x00) must be zero for the frame to act.
- R6: A CRC-enabled frame with a nonzero remainder writes nothing, feeds nothing, and sets the CRC fault flag.
- R7: A read (0x02) drives data bits [5:0] onto `rd_sel` and samples `rd_data` one cycle later. SDO shows bit 15 before the first falling SCLK of the next frame and advances one bit per falling SCLK edge, with zeros after bit 0.
- R8: With the watchdog enabled, the watchdog fault flag sets exactly LIMIT cycles after the cycle in which the enable or the last feed took effect, where LIMIT = timeout_ms x TICKS_PER_MS.
- R9: A feed whose action falls on the expiry cycle restarts the count, and no fault is raised.
- R10: A 0x56 write with data bit 0 set clears both flags and the configuration. Writing the configuration with CRC disabled clears the CRC flag, and writing it with the watchdog disabled clears the watchdog flag.
- R11: After reset `wr_valid` and `sdo` are low. `alarm_n` is low exactly while at least one fault flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| latch | input | 1 | Frame latch; rising edge decodes |
| rd_data | input | 16 | Register value selected by `rd_sel` |
| sdo | output | 1 | Serial read-back data |
| wr_valid | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Address of the write |
| wr_data | output | 16 | Data of the write |
| rd_sel | output | 6 | Read-back register select |
| alarm_n | output | 1 | Low while any fault flag is set |

## Verification
The watchdog expiry and a feed command can resolve in the same clock cycle. The same holds for expiry and a software reset. The bench pre-shifts a feed frame and then times the latch edge so that the decode lands exactly on the cycle in which the counter reaches its limit. It then checks that the feed wins and `alarm_n` stays high. A cycle-accurate reference model in the bench tracks the counter and both flags. It compares `alarm_n` and the write strobe on every clock, so an off-by-one in the expiry or the wrong priority shows up in the cycle where it happens.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam logic [7:0] A_NOP   = 8'h00;
    localparam logic [7:0] A_DATA  = 8'h01;
    localparam logic [7:0] A_READ  = 8'h02;
    localparam logic [7:0] A_CTRL  = 8'h55;
    localparam logic [7:0] A_RESET = 8'h56;
    localparam logic [7:0] A_CFG   = 8'h57;
    localparam logic [7:0] A_GAIN  = 8'h58;
    localparam logic [7:0] A_ZERO  = 8'h59;
    localparam logic [7:0] A_FEED  = 8'h95;

    localparam logic [7:0] CRC_POLY = 8'h07;
    localparam int CFG_CRC_BIT = 2;
    localparam int CFG_WD_BIT  = 3;

    // CRC-8 remainder of a full 32-bit frame, MSB first, zero seed
    function automatic logic [7:0] crc_rem(input logic [31:0] frm);
        logic [7:0] r;
        logic       fb;
        r = 8'h00;
        for (int i = 31; i >= 0; i--) begin
            fb = r[7] ^ frm[i];
            r  = {r[6:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

    // watchdog timeout in milliseconds per select code
    function automatic int unsigned wd_ms(input logic [1:0] sel);
        case (sel)
            2'd0:    return 10;
            2'd1:    return 51;
            2'd2:    return 102;
            default: return 204;
        endcase
    endfunction

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d    = q;
        d.s1 = async_in;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign level = q.s2;
    assign rise  = q.s2 & ~q.s3;
    assign fall  = ~q.s2 & q.s3;

endmodule

// File: rtl/spi_cmd_wdog.sv
module spi_cmd_wdog
    import spi_cmd_pkg::*;
#(
    parameter int TICKS_PER_MS = 50000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] sel,
    input  logic       feed,
    input  logic       kill,
    output logic       flt
);
    localparam int MAX_LIM = 204 * TICKS_PER_MS;
    localparam int CW      = $clog2(MAX_LIM + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flt;
    } wd_t;

    wd_t d, q;
    logic [CW-1:0] lim;

    always_comb begin
        lim = CW'(wd_ms(sel) * TICKS_PER_MS);
        d   = q;
        if (kill) begin
            d.cnt = '0;
            d.flt = 1'b0;
        end else if (feed || !en) begin
            d.cnt = '0;
        end else if (q.cnt >= lim - CW'(1)) begin
            d.cnt = '0;
            d.flt = 1'b1;
        end else begin
            d.cnt = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flt = q.flt;

    // R10: a disabled watchdog never holds a fault
    a_r10_wd_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !q.flt);

    // R8: the fault can only appear while the watchdog was running
    a_r8_fault_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.flt) |-> $past(en));

endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
    import spi_cmd_pkg::*;
#(
    parameter int TICKS_PER_MS = 50000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk,
    input  logic        sdi,
    input  logic        latch,
    input  logic [15:0] rd_data,
    output logic        sdo,
    output logic        wr_valid,
    output logic [7:0]  wr_addr,
    output logic [15:0] wr_data,
    output logic [5:0]  rd_sel,
    output logic        alarm_n
);
    typedef struct packed {
        logic [31:0] sh_in;
        logic [15:0] sh_out;
        logic [5:0]  rd_sel;
        logic        load_pend;
        logic        wr_valid;
        logic [7:0]  wr_addr;
        logic [15:0] wr_data;
        logic        crc_en;
        logic        wd_en;
        logic [1:0]  wd_sel;
        logic        crc_flt;
    } st_t;

    st_t d, q;

    logic [2:0]  s_lvl, s_rise, s_fall;
    logic [23:0] cmd;
    logic        crc_bad, feed, kill, wd_flt;

    spi_cmd_sync #(.W(3)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({latch, sclk, sdi}),
        .level    (s_lvl),
        .rise     (s_rise),
        .fall     (s_fall)
    );

    always_comb begin
        d            = q;
        d.wr_valid   = 1'b0;
        d.load_pend  = 1'b0;
        feed         = 1'b0;
        kill         = 1'b0;
        cmd          = q.crc_en ? q.sh_in[31:8] : q.sh_in[23:0];
        crc_bad      = q.crc_en && (crc_rem(q.sh_in) != 8'h00);

        if (s_rise[1]) d.sh_in = {q.sh_in[30:0], s_lvl[0]};

        if (q.load_pend)    d.sh_out = rd_data;
        else if (s_fall[1]) d.sh_out = {q.sh_out[14:0], 1'b0};

        if (s_rise[2]) begin
            if (crc_bad) begin
                d.crc_flt = 1'b1;
            end else begin
                case (cmd[23:16])
                    A_DATA, A_CTRL, A_GAIN, A_ZERO: begin
                        d.wr_valid = 1'b1;
                        d.wr_addr  = cmd[23:16];
                        d.wr_data  = cmd[15:0];
                    end
                    A_CFG: begin
                        d.wr_valid = 1'b1;
                        d.wr_addr  = cmd[23:16];
                        d.wr_data  = cmd[15:0];
                        d.crc_en   = cmd[CFG_CRC_BIT];
                        d.wd_en    = cmd[CFG_WD_BIT];
                        d.wd_sel   = cmd[1:0];
                        if (!cmd[CFG_CRC_BIT]) d.crc_flt = 1'b0;
                        if (!cmd[CFG_WD_BIT])  kill      = 1'b1;
                    end
                    A_RESET: begin
                        d.wr_valid = 1'b1;
                        d.wr_addr  = cmd[23:16];
                        d.wr_data  = cmd[15:0];
                        if (cmd[0]) begin
                            d.crc_en  = 1'b0;
                            d.wd_en   = 1'b0;
                            d.wd_sel  = 2'd0;
                            d.crc_flt = 1'b0;
                            kill      = 1'b1;
                        end
                    end
                    A_READ: begin
                        d.rd_sel    = cmd[5:0];
                        d.load_pend = 1'b1;
                    end
                    A_FEED:  feed = 1'b1;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    spi_cmd_wdog #(.TICKS_PER_MS(TICKS_PER_MS)) u_wdog (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (q.wd_en),
        .sel   (q.wd_sel),
        .feed  (feed),
        .kill  (kill),
        .flt   (wd_flt)
    );

    assign sdo      = q.sh_out[15];
    assign wr_valid = q.wr_valid;
    assign wr_addr  = q.wr_addr;
    assign wr_data  = q.wr_data;
    assign rd_sel   = q.rd_sel;
    assign alarm_n  = ~(q.crc_flt | wd_flt);

    // R2: the write strobe lasts exactly one cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R3: only writable addresses reach the strobe
    a_r3_addr_legal: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr == A_DATA || wr_addr == A_CTRL || wr_addr == A_RESET ||
                      wr_addr == A_CFG  || wr_addr == A_GAIN || wr_addr == A_ZERO));

    // R6: a frame that raises the CRC fault writes nothing
    a_r6_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.crc_flt) |-> !wr_valid);

    // R7: the read-back word leads with its MSB
    a_r7_sdo_load: assert property (@(posedge clk) disable iff (!rst_n)
        q.load_pend |=> sdo == $past(rd_data[15]));

    // R11: the alarm only falls while a checking feature was on
    a_r11_alarm_src: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_n) |-> ($past(q.crc_en) || $past(q.wd_en)));

endmodule

// File: tb/spi_cmd_rx_tb.sv
module spi_cmd_rx_tb;
    localparam int TPM = 4;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        sclk = 1'b0, sdi = 1'b0, latch = 1'b0;
    logic [15:0] rd_data;
    logic        sdo, wr_valid, alarm_n;
    logic [7:0]  wr_addr;
    logic [15:0] wr_data;
    logic [5:0]  rd_sel;

    int vectors = 0, miscompares = 0, n_wr = 0, cyc = 0, last_ev = 0;
    bit done = 0;

    int          ev_time[$];
    logic [23:0] ev_cmd[$];
    bit          ev_bad[$];

    // model state
    bit m_crc_en = 0, m_wd_en = 0, m_crc_flt = 0, m_wd_flt = 0, m_valid = 0;
    logic [1:0]  m_sel = 0;
    logic [7:0]  m_addr = 0;
    logic [15:0] m_data = 0;
    int          m_cnt = 0;

    always #10 clk = ~clk;

    assign rd_data = {~rd_sel, 10'h2C7};

    spi_cmd_rx #(.TICKS_PER_MS(TPM)) u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .latch(latch),
        .rd_data(rd_data), .sdo(sdo), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_sel(rd_sel), .alarm_n(alarm_n)
    );

    function automatic int lim_of(input logic [1:0] s);
        int ms[4] = '{10, 51, 102, 204};
        return ms[s] * TPM;
    endfunction

    function automatic logic [7:0] crc8_ref(input logic [23:0] m);
        logic [7:0] r;
        r = 8'h00;
        for (int b = 2; b >= 0; b--) begin
            r = r ^ m[b*8 +: 8];
            for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // cycle-accurate reference model
    always @(posedge clk) begin
        bit n_crc_en, n_wd_en, n_crc_flt, feed, kill, bad;
        logic [1:0] n_sel;
        logic [23:0] c;
        cyc++;
        if (!rst_n) begin
            m_crc_en = 0; m_wd_en = 0; m_crc_flt = 0; m_wd_flt = 0; m_valid = 0;
            m_sel = 0; m_cnt = 0;
        end else begin
            m_valid = 0; feed = 0; kill = 0;
            n_crc_en = m_crc_en; n_wd_en = m_wd_en; n_crc_flt = m_crc_flt; n_sel = m_sel;
            if (ev_time.size() > 0 && ev_time[0] == cyc) begin
                void'(ev_time.pop_front());
                c = ev_cmd.pop_front();
                bad = ev_bad.pop_front();
                if (m_crc_en && bad) n_crc_flt = 1;
                else begin
                    if (c[23:16] inside {8'h01, 8'h55, 8'h56, 8'h57, 8'h58, 8'h59}) begin
                        m_valid = 1; m_addr = c[23:16]; m_data = c[15:0];
                    end
                    if (c[23:16] == 8'h57) begin
                        n_crc_en = c[2]; n_wd_en = c[3]; n_sel = c[1:0];
                        if (!c[2]) n_crc_flt = 0;
                        if (!c[3]) kill = 1;
                    end
                    if (c[23:16] == 8'h56 && c[0]) begin
                        n_crc_en = 0; n_wd_en = 0; n_sel = 0; n_crc_flt = 0; kill = 1;
                    end
                    if (c[23:16] == 8'h95) feed = 1;
                end
            end
            if (kill) begin m_cnt = 0; m_wd_flt = 0; end
            else if (feed || !m_wd_en) m_cnt = 0;
            else if (m_cnt >= lim_of(m_sel) - 1) begin m_cnt = 0; m_wd_flt = 1; end
            else m_cnt++;
            m_crc_en = n_crc_en; m_wd_en = n_wd_en; m_crc_flt = n_crc_flt; m_sel = n_sel;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(alarm_n == !(m_crc_flt || m_wd_flt), "R11 alarm_n per clock", alarm_n, !(m_crc_flt || m_wd_flt));
            chk(wr_valid == m_valid, "R2 wr_valid per clock", wr_valid, m_valid);
            if (m_valid) chk({wr_addr, wr_data} == {m_addr, m_data}, "R2 write payload", {wr_addr, wr_data}, {m_addr, m_data});
            if (wr_valid) n_wr++;
        end
    end

    task automatic shift_bits(input logic [31:0] v, input int n, input bit chk_sdo, input logic [15:0] exp_sdo);
        for (int i = n - 1; i >= 0; i--) begin
            int k;
            k = n - 1 - i;
            sdi = v[i];
            repeat (4) @(negedge clk);
            if (chk_sdo && k < 20) begin
                logic e;
                e = (k < 16) ? exp_sdo[15-k] : 1'b0;
                chk(sdo == e, "R7 sdo bit", sdo, e);
            end
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
        sdi = 1'b0;
    endtask

    task automatic pulse_latch(input logic [23:0] c, input bit bad, input int at);
        @(negedge clk);
        while (at > 0 && cyc < at - 3) @(negedge clk);
        if (at > 0) chk(cyc == at - 3, "R9 latch timing", cyc, at - 3);
        latch = 1'b1;
        ev_time.push_back(cyc + 3); ev_cmd.push_back(c); ev_bad.push_back(bad);
        last_ev = cyc + 3;
        repeat (3) @(negedge clk);
        latch = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] a, input logic [15:0] dt, input bit crcm, input bit corrupt,
                         input int at, input bit chk_sdo, input logic [15:0] exp_sdo);
        logic [23:0] c;
        logic [7:0]  cr;
        c = {a, dt};
        if (crcm) begin
            cr = crc8_ref(c) ^ {7'd0, corrupt};
            shift_bits({c, cr}, 32, chk_sdo, exp_sdo);
        end else shift_bits({8'd0, c}, 24, chk_sdo, exp_sdo);
        pulse_latch(c, crcm && corrupt, at);
    endtask

    task automatic wr24(input logic [7:0] a, input logic [15:0] dt);
        frame(a, dt, 0, 0, 0, 0, 16'h0);
    endtask

    task automatic finish_run;
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        vectors++; miscompares++;
        $display("FAIL watchdog run did not complete actual=hung expected=done");
        finish_run;
    end

    initial begin
        int t0, w0;
        repeat (5) @(negedge clk);
        chk(wr_valid == 0, "R11 reset wr_valid", wr_valid, 0);
        chk(alarm_n == 1, "R11 reset alarm_n", alarm_n, 1);
        chk(sdo == 0, "R11 reset sdo", sdo, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1/R2: basic writes
        wr24(8'h01, 16'hBEEF);
        chk({wr_addr, wr_data} == 24'h01BEEF, "R1 field order", {wr_addr, wr_data}, 24'h01BEEF);
        wr24(8'h55, 16'h1234);
        wr24(8'h58, 16'h8000);
        wr24(8'h59, 16'hFF01);
        chk(n_wr == 4, "R2 strobe count", n_wr, 4);

        // R1: bits shift while latch high, act only on the next rise
        wr24(8'h00, 16'h0000);
        @(negedge clk); latch = 1'b1;
        ev_time.push_back(cyc + 3); ev_cmd.push_back(24'h000000); ev_bad.push_back(0);
        shift_bits({8'd0, 24'h01A5A5}, 24, 0, 16'h0);
        chk(n_wr == 4, "R1 no action while latch high", n_wr, 4);
        latch = 1'b0; repeat (5) @(negedge clk);
        pulse_latch(24'h01A5A5, 0, 0);
        chk(n_wr == 5 && wr_data == 16'hA5A5, "R1 act on rising latch", wr_data, 16'hA5A5);

        // R3: ignored addresses
        wr24(8'h33, 16'hFFFF);
        wr24(8'h00, 16'h1111);
        wr24(8'h95, 16'h0000);
        chk(n_wr == 5, "R3 no strobe for ignored addresses", n_wr, 5);

        // R7: read-back
        wr24(8'h02, 16'h002D);
        chk(rd_sel == 6'h2D, "R7 rd_sel", rd_sel, 6'h2D);
        frame(8'h02, 16'h0012, 0, 0, 0, 1, {~6'h2D, 10'h2C7});
        chk(rd_sel == 6'h12, "R7 rd_sel second", rd_sel, 6'h12);
        frame(8'h00, 16'h0000, 0, 0, 0, 1, {~6'h12, 10'h2C7});
        chk(n_wr == 5, "R3 read makes no strobe", n_wr, 5);

        // R4/R8: short timeout select 00
        wr24(8'h57, 16'h0008);
        w0 = last_ev;
        while (cyc < w0 + lim_of(2'd0) - 1) @(negedge clk);
        chk(alarm_n == 1, "R8 before expiry sel0", alarm_n, 1);
        @(negedge clk);
        chk(alarm_n == 0, "R4 R8 expiry sel0", alarm_n, 0);
        wr24(8'h57, 16'h0000);
        chk(alarm_n == 1, "R10 disable clears wd fault", alarm_n, 1);

        // R9: feed lands on expiry cycle (select 10)
        wr24(8'h57, 16'h000A);
        t0 = last_ev;
        frame(8'h95, 16'h0000, 0, 0, t0 + lim_of(2'd2), 0, 16'h0);
        chk(alarm_n == 1, "R9 feed on expiry wins", alarm_n, 1);
        t0 = last_ev;
        while (cyc < t0 + lim_of(2'd2) - 1) @(negedge clk);
        chk(alarm_n == 1, "R8 one cycle before expiry", alarm_n, 1);
        @(negedge clk);
        chk(alarm_n == 0, "R8 expiry cycle", alarm_n, 0);
        wr24(8'h95, 16'h0000);
        chk(alarm_n == 0, "R8 feed keeps sticky fault", alarm_n, 0);
        wr24(8'h56, 16'h0001);
        chk(alarm_n == 1, "R10 software reset clears", alarm_n, 1);

        // R5/R6: CRC framing
        wr24(8'h57, 16'h0004);
        frame(8'h01, 16'h4242, 1, 0, 0, 0, 16'h0);
        chk(wr_data == 16'h4242 && alarm_n == 1, "R5 good crc frame", wr_data, 16'h4242);
        frame(8'h01, 16'h9999, 1, 1, 0, 0, 16'h0);
        chk(wr_data == 16'h4242, "R6 bad frame blocked", wr_data, 16'h4242);
        chk(alarm_n == 0, "R6 crc fault", alarm_n, 0);
        frame(8'h56, 16'h0001, 1, 1, 0, 0, 16'h0);
        chk(alarm_n == 0, "R6 bad reset blocked", alarm_n, 0);
        frame(8'h57, 16'h0000, 1, 0, 0, 0, 16'h0);
        chk(alarm_n == 1, "R10 crc disable clears", alarm_n, 1);
        wr24(8'h58, 16'h0777);
        chk(wr_data == 16'h0777, "R5 back to 24-bit frames", wr_data, 16'h0777);

        // R10: reset also clears a CRC fault and configuration
        wr24(8'h57, 16'h0004);
        frame(8'h59, 16'h0000, 1, 1, 0, 0, 16'h0);
        chk(alarm_n == 0, "R6 fault again", alarm_n, 0);
        frame(8'h56, 16'h0001, 1, 0, 0, 0, 16'h0);
        chk(alarm_n == 1, "R10 reset clears crc fault", alarm_n, 1);
        wr24(8'h01, 16'h0F0F);
        chk(wr_data == 16'h0F0F, "R10 reset restores 24-bit framing", wr_data, 16'h0F0F);

        repeat (10) @(negedge clk);
        finish_run;
    end
endmodule